// File: doc/BRIEF.md
# Prescaled Reloading Wake-Up Timer

This block is a 23-bit system timer that keeps counting while the rest of the chip sleeps. A 7-bit prescaler counts down on every enabled clock. Each time it passes from zero back to its top value, it steps a 16-bit down-counter. When both stages are zero together, the counter takes a fresh start value from a software-programmed reload register and sets an expiry flag. The flag, qualified by an interrupt enable, becomes the wake-up and interrupt request.

Software uses a small register bus. One write port selects one of two registers: a control word and the 16-bit reload value. One read port returns the control word, the reload value, the live counter or the live prescaler. The interval between expiries is (reload + 1) × 128 enabled clocks.

Top module: `rtc_wake_timer`

## Requirements
- R1: After reset the timer is disabled, the interrupt enable and the flag are 0, the reload value and the live counter are all ones, and the prescaler holds 127.
- R2: On every clock while enabled, the prescaler decreases by one. When it is 0 it returns to 127 instead.
- R3: When the prescaler returns from 0 to 127 and the live counter is nonzero, the counter decreases by one. At any other time while enabled it holds its value.
- R4: When the prescaler and the counter are both 0 on an enabled clock, the counter is loaded with the reload value held before that edge and the flag becomes 1. With reload value N, the flag is set once every (N+1)×128 enabled clocks.
- R5: A write to the reload register (address 1) while the timer is disabled also loads the live counter. While the timer is enabled, the write changes only the reload register, and the live counter first sees the new value at its next reload.
- R6: A control write (address 0) with bit 2 = 0 clears the flag. Bit 2 = 1 leaves the flag unchanged and never sets it. An expiry in the same cycle as a clearing write leaves the flag set.
- R7: The wake output is 1 exactly when the flag and the interrupt enable are both 1.
- R8: Control bit 0 enables counting and bit 1 is the interrupt enable. Clearing bit 0 freezes both stages. A write that sets bit 0 while the timer is disabled restarts the prescaler at 127. The same write while the timer is already enabled leaves the prescaler running.
- R9: The read port returns a value that depends on the read address. Address 0 gives the control word: bit 0 enable, bit 1 interrupt enable, bit 2 flag, upper bits 0. Address 1 gives the reload value. Address 2 gives the live counter. Address 3 gives the prescaler, zero-extended.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Timer clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | 1 | Write select: 0 control, 1 reload |
| wr_data | input | 16 | Write data |
| rd_addr | input | 2 | Read select |
| rd_data | output | 16 | Read data, combinational from the read select |
| flag_o | output | 1 | Expiry flag |
| wake_o | output | 1 | Wake-up and interrupt request |

## Verification
A prescaler that is off by even one step shows up one cycle later as a wrong value at read address 3. It also shifts every later counter step and expiry by that amount, so the flag edge moves away from the predicted cycle. A wrong counter or reload state first appears at read address 2. If it is not read there, it appears at the next expiry, at most (N+1)×128 cycles later, as a flag or wake edge in the wrong cycle. The bench rotates the read address every cycle and compares the flag and wake pins on every clock. A frozen-state or lost-write fault is therefore seen within four cycles.

// File: rtl/rtc_wake_timer.sv
module rtc_wake_timer #(
  parameter int PRE_W = 7,
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic             wr_addr,
  input  logic [CNT_W-1:0] wr_data,
  input  logic [1:0]       rd_addr,
  output logic [CNT_W-1:0] rd_data,
  output logic             flag_o,
  output logic             wake_o
);
  localparam logic [PRE_W-1:0] PRE_TOP = {PRE_W{1'b1}};
  localparam logic [CNT_W-1:0] CNT_TOP = {CNT_W{1'b1}};

  logic             en_q, ie_q, flag_q;
  logic [PRE_W-1:0] pre_q;
  logic [CNT_W-1:0] cnt_q, rel_q;

  wire ctrl_wr = wr_en && !wr_addr;
  wire rel_wr  = wr_en &&  wr_addr;
  wire wrap    = en_q && (pre_q == '0);
  wire expire  = wrap && (cnt_q == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= 1'b0;
      ie_q   <= 1'b0;
      flag_q <= 1'b0;
      pre_q  <= PRE_TOP;
      cnt_q  <= CNT_TOP;
      rel_q  <= CNT_TOP;
    end else begin
      if (en_q)
        pre_q <= wrap ? PRE_TOP : pre_q - 1'b1;
      else if (ctrl_wr && wr_data[0])
        pre_q <= PRE_TOP;

      if (expire)
        cnt_q <= rel_q;
      else if (wrap)
        cnt_q <= cnt_q - 1'b1;
      else if (rel_wr && !en_q)
        cnt_q <= wr_data;

      if (rel_wr)
        rel_q <= wr_data;

      if (ctrl_wr) begin
        en_q <= wr_data[0];
        ie_q <= wr_data[1];
      end

      if (expire)
        flag_q <= 1'b1;
      else if (ctrl_wr && !wr_data[2])
        flag_q <= 1'b0;
    end
  end

  always_comb begin
    rd_data = '0;
    case (rd_addr)
      2'd0:    rd_data[2:0] = {flag_q, ie_q, en_q};
      2'd1:    rd_data = rel_q;
      2'd2:    rd_data = cnt_q;
      default: rd_data[PRE_W-1:0] = pre_q;
    endcase
  end

  assign flag_o = flag_q;
  assign wake_o = flag_q & ie_q;

  // R2
  pre_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    en_q && pre_q != '0 |=> pre_q == $past(pre_q) - 1'b1);
  // R2
  pre_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    en_q && pre_q == '0 |=> pre_q == PRE_TOP);
  // R3
  cnt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    en_q && pre_q != '0 |=> $stable(cnt_q));
  // R4
  reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
    en_q && pre_q == '0 && cnt_q == '0 |=> flag_q && cnt_q == $past(rel_q));
  // R8
  frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en_q && !(wr_en && !wr_addr && wr_data[0]) |=> $stable(pre_q));
  // R6
  clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && !wr_addr && !wr_data[2] && !(en_q && pre_q == '0 && cnt_q == '0) |=> !flag_q);
endmodule

// File: tb/rtc_wake_timer_tb.sv
`timescale 1ns/1ps
module rtc_wake_timer_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic        wr_addr = 1'b0;
  logic [15:0] wr_data = '0;
  logic [1:0]  rd_addr = '0;
  logic [15:0] rd_data;
  logic        flag_o, wake_o;

  rtc_wake_timer dut_i (.clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data), .flag_o(flag_o), .wake_o(wake_o));

  always #2.5 clk = ~clk;

  int checks = 0, errors = 0, cycles = 0, rsel = 0;
  int m_en = 0, m_ie = 0, m_flag = 0, m_pre = 127, m_cnt = 65535, m_rel = 65535;

  function automatic int mread(int a);
    case (a)
      0: return m_flag * 4 + m_ie * 2 + m_en;
      1: return m_rel;
      2: return m_cnt;
      default: return m_pre;
    endcase
  endfunction

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s cycle=%0d act=%0d exp=%0d", req, cycles, act, exp);
    end
  endtask

  task automatic compare_all();
    string tag [4] = '{"R9/R8 ctrl", "R5 reload", "R3/R4 count", "R2 prescaler"};
    rd_addr = 2'(rsel);
    #1;
    check(tag[rsel], int'(rd_data), mread(rsel));
    check("R6 flag", int'(flag_o), m_flag);
    check("R7 wake", int'(wake_o), m_flag & m_ie);
    rsel = (rsel + 1) % 4;
  endtask

  // one clock: drive inputs, update the reference at the edge, compare after
  task automatic cyc(bit w, int a, int d);
    bit was_en, uf;
    wr_en = w; wr_addr = a[0]; wr_data = 16'(d);
    @(posedge clk);
    cycles++;
    was_en = (m_en != 0);
    uf = 0;
    if (was_en) begin
      if (m_pre == 0) begin
        m_pre = 127;
        if (m_cnt == 0) begin m_cnt = m_rel; m_flag = 1; uf = 1; end
        else m_cnt = m_cnt - 1;
      end else m_pre = m_pre - 1;
    end
    if (w && a == 0) begin
      if (!was_en && d[0]) m_pre = 127;
      m_en = d[0]; m_ie = d[1];
      if (!d[2] && !uf) m_flag = 0;
    end
    if (w && a == 1) begin
      m_rel = d & 16'hFFFF;
      if (!was_en) m_cnt = m_rel;
    end
    @(negedge clk);
    wr_en = 1'b0;
    compare_all();
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) cyc(0, 0, 0);
  endtask

  initial begin
    while (cycles < 200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1: reset state on every read address
    for (int a = 0; a < 4; a++) begin
      rd_addr = 2'(a); #1;
      check("R1 reset read", int'(rd_data), mread(a));
    end
    check("R1 reset flag", int'(flag_o), 0);
    check("R1 reset wake", int'(wake_o), 0);
    idle(6);
    cyc(1, 1, 3);            // R5 load while disabled
    cyc(1, 0, 3);            // R8 enable + interrupt enable
    idle(1100);              // R4 two expiries at reload 3
    cyc(1, 0, 7);            // R6 writing 1 to flag bit keeps it
    cyc(1, 0, 3);            // R6 clear
    cyc(1, 1, 1);            // R5 write while enabled
    idle(700);
    cyc(1, 0, 2);            // R8 disable, freeze
    idle(40);
    cyc(1, 1, 0);            // R5 load counter while disabled
    idle(5);
    cyc(1, 0, 1);            // R8 re-enable, ie off: R7 wake low
    idle(300);
    cyc(1, 0, 5);            // R8 enable write while enabled: no restart
    for (int i = 0; i < 400; i++) cyc(1, 0, 3);   // R6 clears colliding with expiries
    idle(20);
    cyc(1, 1, 65535);
    cyc(1, 0, 2);            // R8 disable
    cyc(1, 0, 3);            // R8 restart prescaler at 127
    idle(260);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule